// File: doc/BRIEF.md
# Serial Display Command Receiver

This block is the serial input stage of a ten-character dot-matrix display controller. Each character is a 5 x 5 grid. A host sends 8-bit command words over a three-wire link: an active-low framing gate, a serial clock and a serial data line. The block oversamples the three wires with its own system clock and brings them through a synchronizer. While the gate is low, it captures one data bit on each rising edge of the serial clock.

When the gate returns high, the block decodes the captured word. The top three bits form an opcode and the low five bits are its argument. The argument goes to one of three places: a character pointer, one row of pixel data in an internal 250-bit pixel store, or a control register. The scan logic reads the pixel store through its own combinational port. That port works independently of the write side. The meaning of the control-register bits is decided elsewhere.

Top module: `ser_disp_rx`

## Requirements
- R1: A bit is captured only on a rising edge of `ser_clk` seen while `ser_gate_n` is low. Edges and data while the gate is high leave the next word unchanged.
- R2: Words arrive bit 0 first, and exactly eight captured bits make a word. Bit 7 is the last bit sent.
- R3: A word is acted on only when `ser_gate_n` rises. If that rise follows any count of captured bits other than eight, the word is dropped with no effect.
- R4: Opcodes 0 to 4 (bits 7:5) write their argument as row 0 to 4 of the character that `cur_char` points at. Each write raises `ram_wr_en` for one cycle, and no other store location changes.
- R5: Argument bit 4 is column 0 and argument bit 0 is column 4. In `scan_cols` and `ram_wr_cols`, bit c is column c, and 1 means the dot is lit.
- R6: Opcode 5 loads its argument into `cur_char`. While `cur_char` is 10 or more, row writes are dropped and `ram_wr_en` stays low.
- R7: Opcode 6 loads its argument into `ctrl_word` and pulses `ctrl_upd` for one cycle. `ctrl_word` changes only on opcode 6.
- R8: Opcode 7 changes nothing: no store write, no pointer change, no control change.
- R9: After a synchronous active-low reset, the whole pixel store reads 0, and `cur_char` and `ctrl_word` are 0.
- R10: `scan_cols` is a combinational read of (`scan_char`, `scan_row`). A character of 10 or more, or a row of 5 or more, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples the serial wires |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_gate_n | input | 1 | Framing gate; low opens a word and the rising edge commits it |
| ser_clk | input | 1 | Serial bit clock; a bit is taken on its rising edge |
| ser_dat | input | 1 | Serial data, bit 0 first |
| scan_char | input | 5 | Read port: character index |
| scan_row | input | 3 | Read port: row index |
| scan_cols | output | 5 | Read port: row pixels, bit c = column c |
| ctrl_word | output | 5 | Control register |
| ctrl_upd | output | 1 | One-cycle pulse when the control register is loaded |
| cur_char | output | 5 | Character pointer used by row writes |
| ram_wr_en | output | 1 | Store write strobe |
| ram_wr_char | output | 5 | Store write character |
| ram_wr_row | output | 3 | Store write row |
| ram_wr_cols | output | 5 | Store write pixels, bit c = column c |

## Verification
The assertions assume that every level on the serial wires lasts longer than the synchronizer depth plus one system clock. They also assume that no serial clock edge lands in the same sampled cycle as a gate edge, so that each edge is seen once and in order. The bench meets both conditions: it holds every wire level for at least three system clocks, and it waits several clocks between a gate edge and the next serial clock edge. Random traffic mixes all eight opcodes and pointer values on both sides of the range limit, and some words are sent with too few or too many bits.

// File: rtl/ser_disp_pkg.sv
// Package: shared sizes and the opcode encoding of the serial display receiver.
// Assumes: opcodes 0..4 are row numbers, so their numeric value is the row index.
package ser_disp_pkg;
    localparam int WORD_W = 8;
    localparam int ARG_W  = 5;
    localparam int OP_W   = 3;
    localparam int ROW_W  = 3;
    localparam int NROW   = 5;
    localparam int NCOL   = 5;
    localparam int CNT_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ROW0 = 3'd0,
        OP_ROW1 = 3'd1,
        OP_ROW2 = 3'd2,
        OP_ROW3 = 3'd3,
        OP_ROW4 = 3'd4,
        OP_CHAR = 3'd5,
        OP_CTRL = 3'd6,
        OP_NOP  = 3'd7
    } op_e;
endpackage

// File: rtl/ser_disp_sync.sv
// Module: brings W asynchronous wires into the clk domain through STAGES flops,
// then reports the settled level and single-cycle rise/fall flags.
// Assumes: every input level lasts at least STAGES+1 clk cycles.
module ser_disp_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] prev;

    // First stage: capture the raw wires.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= din;
    end

    // Remaining stages of the synchronizer chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
        end
    end

    // Previous settled level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= pipe[STAGES-1];
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/ser_disp_shift.sv
// Module: assembles serial bits into a word, bit 0 first, while the gate is low,
// and offers the word for one cycle at the gate rise if exactly WORD_W bits came.
// Assumes: synchronized inputs; no bit edge in the same cycle as a gate edge.
module ser_disp_shift
    import ser_disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_lvl,
    input  logic              gate_rise,
    input  logic              gate_fall,
    input  logic              bit_rise,
    input  logic              bit_val,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;

    // Shift register, bit counter and word hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            cnt      <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (gate_rise) begin
                word_vld <= (cnt == FULL);
                word     <= sr;
                cnt      <= '0;
            end else if (gate_fall) begin
                cnt <= '0;
            end else if (!gate_lvl && bit_rise) begin
                sr  <= {bit_val, sr[WORD_W-1:1]};
                cnt <= (cnt == OVER) ? OVER : cnt + 1'b1;
            end
        end
    end

    AST_WORD_AT_GATE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(gate_rise)); // R3
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= OVER); // R2
    AST_CLOSED_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_lvl && $past(gate_lvl) && $past(gate_lvl, 2)) |-> $stable(cnt)); // R1
endmodule

// File: rtl/ser_disp_decode.sv
// Module: decodes a committed word: rows go to the store at the pointed character,
// opcode 5 loads the pointer, opcode 6 the control register, opcode 7 is dropped.
// Assumes: word_vld is a single-cycle strobe.
module ser_disp_decode
    import ser_disp_pkg::*;
#(
    parameter int NCHAR = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output logic [ARG_W-1:0]  char_q,
    output logic [ARG_W-1:0]  ctrl_q,
    output logic              ctrl_upd,
    output logic              wr_en,
    output logic [ARG_W-1:0]  wr_char,
    output logic [ROW_W-1:0]  wr_row,
    output logic [NCOL-1:0]   wr_cols
);
    localparam logic [ARG_W-1:0] NCHAR_C = ARG_W'(NCHAR);

    op_e              op;
    logic [ARG_W-1:0] arg;
    logic [NCOL-1:0]  cols;

    assign op  = op_e'(word[WORD_W-1 -: OP_W]);
    assign arg = word[ARG_W-1:0];

    // Column reorder: argument bit 4 is column 0.
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        assign cols[c] = arg[NCOL-1-c];
    end

    // Opcode dispatch and registered write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q   <= '0;
            ctrl_q   <= '0;
            ctrl_upd <= 1'b0;
            wr_en    <= 1'b0;
            wr_char  <= '0;
            wr_row   <= '0;
            wr_cols  <= '0;
        end else begin
            ctrl_upd <= 1'b0;
            wr_en    <= 1'b0;
            if (word_vld) begin
                case (op)
                    OP_CHAR: char_q <= arg;
                    OP_CTRL: begin
                        ctrl_q   <= arg;
                        ctrl_upd <= 1'b1;
                    end
                    OP_NOP:  ;
                    default: begin
                        if (char_q < NCHAR_C) begin
                            wr_en   <= 1'b1;
                            wr_char <= char_q;
                            wr_row  <= ROW_W'(op);
                            wr_cols <= cols;
                        end
                    end
                endcase
            end
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_char < NCHAR_C)); // R6
    AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld && op == OP_CHAR) |=> $stable(char_q)); // R6
    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld && op == OP_CTRL) |=> $stable(ctrl_q)); // R7
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && op == OP_NOP) |=> !(wr_en || ctrl_upd)); // R8
endmodule

// File: rtl/ser_disp_ram.sv
// Module: NCHAR x NROW x NCOL pixel store, clocked write port and combinational
// read port; out-of-range reads return 0. Cleared by reset.
// Assumes: the writer only presents in-range addresses.
module ser_disp_ram
    import ser_disp_pkg::*;
#(
    parameter int NCHAR = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ARG_W-1:0] wr_char,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [NCOL-1:0]  wr_cols,
    input  logic [ARG_W-1:0] rd_char,
    input  logic [ROW_W-1:0] rd_row,
    output logic [NCOL-1:0]  rd_cols
);
    localparam int BITS = NCHAR * NROW * NCOL;
    localparam logic [ARG_W-1:0] NCHAR_C = ARG_W'(NCHAR);
    localparam logic [ROW_W-1:0] NROW_C  = ROW_W'(NROW);

    logic [BITS-1:0] mem;
    int              wbase;
    int              rbase;

    // Bit offsets of the addressed rows.
    always_comb begin
        wbase = (int'(wr_char) * NROW + int'(wr_row)) * NCOL;
        rbase = (int'(rd_char) * NROW + int'(rd_row)) * NCOL;
    end

    // Write port.
    always_ff @(posedge clk) begin
        if (!rst_n)     mem <= '0;
        else if (wr_en) mem[wbase +: NCOL] <= wr_cols;
    end

    // Read port with range guard.
    always_comb begin
        if (rd_char < NCHAR_C && rd_row < NROW_C) rd_cols = mem[rbase +: NCOL];
        else                                      rd_cols = '0;
    end

    AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem)); // R4
endmodule

// File: rtl/ser_disp_rx.sv
// Module: top of the serial display command receiver: synchronizer, word
// assembler, opcode decoder and pixel store.
// Assumes: serial wires are asynchronous to clk and slow against it.
module ser_disp_rx
    import ser_disp_pkg::*;
#(
    parameter int NCHAR       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_gate_n,
    input  logic       ser_clk,
    input  logic       ser_dat,
    input  logic [4:0] scan_char,
    input  logic [2:0] scan_row,
    output logic [4:0] scan_cols,
    output logic [4:0] ctrl_word,
    output logic       ctrl_upd,
    output logic [4:0] cur_char,
    output logic       ram_wr_en,
    output logic [4:0] ram_wr_char,
    output logic [2:0] ram_wr_row,
    output logic [4:0] ram_wr_cols
);
    logic [2:0]        lvl, rise, fall;
    logic              word_vld;
    logic [WORD_W-1:0] word;

    ser_disp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk (clk), .rst_n (rst_n),
        .din ({ser_dat, ser_clk, ser_gate_n}),
        .lvl (lvl), .rise (rise), .fall (fall)
    );

    ser_disp_shift u_shift (
        .clk (clk), .rst_n (rst_n),
        .gate_lvl (lvl[0]), .gate_rise (rise[0]), .gate_fall (fall[0]),
        .bit_rise (rise[1]), .bit_val (lvl[2]),
        .word_vld (word_vld), .word (word)
    );

    ser_disp_decode #(.NCHAR(NCHAR)) u_dec (
        .clk (clk), .rst_n (rst_n),
        .word_vld (word_vld), .word (word),
        .char_q (cur_char), .ctrl_q (ctrl_word), .ctrl_upd (ctrl_upd),
        .wr_en (ram_wr_en), .wr_char (ram_wr_char), .wr_row (ram_wr_row),
        .wr_cols (ram_wr_cols)
    );

    ser_disp_ram #(.NCHAR(NCHAR)) u_ram (
        .clk (clk), .rst_n (rst_n),
        .wr_en (ram_wr_en), .wr_char (ram_wr_char), .wr_row (ram_wr_row),
        .wr_cols (ram_wr_cols),
        .rd_char (scan_char), .rd_row (scan_row), .rd_cols (scan_cols)
    );
endmodule

// File: tb/ser_disp_rx_tb.sv
module ser_disp_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate_n = 1'b1, sclk = 1'b0, sdat = 1'b0;
    logic [4:0] scan_char = '0;
    logic [2:0] scan_row = '0;
    logic [4:0] scan_cols, ctrl_word, cur_char, ram_wr_cols, ram_wr_char;
    logic [2:0] ram_wr_row;
    logic       ctrl_upd, ram_wr_en;

    int checks = 0, errors = 0;
    int obs_ctrl = 0, obs_wr = 0, exp_ctrl = 0, exp_wr = 0;
    logic [4:0] ref_mem [10][5];
    logic [4:0] ref_char = '0, ref_ctrl = '0;

    always #4 clk = ~clk;

    ser_disp_rx u_dut (
        .clk (clk), .rst_n (rst_n), .ser_gate_n (gate_n), .ser_clk (sclk),
        .ser_dat (sdat), .scan_char (scan_char), .scan_row (scan_row),
        .scan_cols (scan_cols), .ctrl_word (ctrl_word), .ctrl_upd (ctrl_upd),
        .cur_char (cur_char), .ram_wr_en (ram_wr_en), .ram_wr_char (ram_wr_char),
        .ram_wr_row (ram_wr_row), .ram_wr_cols (ram_wr_cols)
    );

    // Pulse counters for control loads and store writes.
    always @(posedge clk) begin
        if (rst_n && ctrl_upd)  obs_ctrl++;
        if (rst_n && ram_wr_en) obs_wr++;
    end

    function automatic logic [4:0] rev5(input logic [4:0] a);
        for (int i = 0; i < 5; i++) rev5[i] = a[4-i];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Reference model of a committed word.
    task automatic apply(input logic [7:0] w);
        logic [2:0] op = w[7:5];
        logic [4:0] a  = w[4:0];
        if (op < 3'd5) begin
            if (ref_char < 5'd10) begin
                ref_mem[ref_char][op] = rev5(a);
                exp_wr++;
            end
        end else if (op == 3'd5) ref_char = a;
        else if (op == 3'd6) begin
            ref_ctrl = a;
            exp_ctrl++;
        end
    endtask

    task automatic send(input logic [7:0] w, input int nbits);
        @(negedge clk) gate_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdat = w[i % 8];
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (3) @(negedge clk);
        gate_n = 1'b1;
        repeat (10) @(negedge clk);
        if (nbits == 8) apply(w);
    endtask

    task automatic check_ram(input string req);
        for (int c = 0; c < 10; c++)
            for (int r = 0; r < 5; r++) begin
                scan_char = 5'(c);
                scan_row  = 3'(r);
                #1;
                chk(req, 32'(scan_cols), 32'(ref_mem[c][r]));
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] w;
        int nb;
        void'($urandom(32'd4242));
        for (int c = 0; c < 10; c++)
            for (int r = 0; r < 5; r++) ref_mem[c][r] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: reset state
        chk("R9 ctrl", 32'(ctrl_word), 0);
        chk("R9 ptr", 32'(cur_char), 0);
        check_ram("R9 store");
        // R10: out-of-range reads
        scan_char = 5'd12; scan_row = 3'd1; #1; chk("R10 char", 32'(scan_cols), 0);
        scan_char = 5'd0;  scan_row = 3'd6; #1; chk("R10 row", 32'(scan_cols), 0);

        // R4 R5 R2: letter shape at character 3
        send(8'hA3, 8);
        chk("R6 ptr", 32'(cur_char), 3);
        send(8'h1E, 8); send(8'h31, 8); send(8'h51, 8); send(8'h71, 8); send(8'h9E, 8);
        scan_char = 5'd3; scan_row = 3'd0; #1; chk("R5 row0", 32'(scan_cols), 32'h0F);
        scan_row = 3'd1; #1; chk("R5 row1", 32'(scan_cols), 32'h11);
        check_ram("R4 letter");

        // R6: out-of-range pointer drops rows
        send(8'hAF, 8);
        chk("R6 ptr15", 32'(cur_char), 15);
        send(8'h1F, 8);
        chk("R6 no write", obs_wr, exp_wr);
        check_ram("R6 store");
        send(8'hA0, 8);

        // R3: short and long words dropped
        send(8'hC5, 7);
        chk("R3 short", 32'(ctrl_word), 32'(ref_ctrl));
        send(8'hC5, 9);
        chk("R3 long", 32'(ctrl_word), 32'(ref_ctrl));

        // R7: control load
        send(8'hD5, 8);
        chk("R7 ctrl", 32'(ctrl_word), 32'h15);
        chk("R7 pulses", obs_ctrl, exp_ctrl);

        // R8: opcode 7 ignored
        send(8'hFF, 8);
        chk("R8 ctrl", 32'(ctrl_word), 32'h15);
        chk("R8 ptr", 32'(cur_char), 0);
        chk("R8 writes", obs_wr, exp_wr);
        check_ram("R8 store");

        // R1: clock edges with the gate high are not captured
        sdat = 1'b1;
        for (int i = 0; i < 5; i++) begin
            repeat (3) @(negedge clk); sclk = 1'b1;
            repeat (3) @(negedge clk); sclk = 1'b0;
        end
        repeat (5) @(negedge clk);
        send(8'hC3, 8);
        chk("R1 gate high", 32'(ctrl_word), 3);

        // Random traffic
        for (int n = 0; n < 250; n++) begin
            w = 8'($urandom);
            if (w[7:5] == 3'd5) w[4:0] = 5'($urandom % 12);
            nb = 8;
            if ($urandom % 10 == 0) begin
                nb = 1 + int'($urandom % 8);
                if (nb == 8) nb = 9;
            end
            send(w, nb);
            chk("R7 rand ctrl", 32'(ctrl_word), 32'(ref_ctrl));
            chk("R6 rand ptr", 32'(cur_char), 32'(ref_char));
            if (n % 50 == 49) check_ram("R4 rand store");
        end
        chk("R7 total pulses", obs_ctrl, exp_ctrl);
        chk("R4 total writes", obs_wr, exp_wr);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule